// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block models a synchronous static memory with a read port and a write port that run on their own, each with its own address and data bus. Every access moves a fixed burst of four data beats. Two beats move in each clock cycle, one on the rising edge and one on the falling edge. At the core boundary these are carried as a rising-edge lane and a falling-edge lane, sampled together on each rising clock edge. The write side collects the four beats and a per-beat set of byte-lane enables, then updates one array word four beats wide in a single operation. The read side fetches one such wide word and sends its beats out in order over two cycles.

Each address selects one group of four beats, so the address is two bits narrower than the beat index. A read issued on the same edge as a write to the same address, or on any later edge, returns the newly written data. A read issued before that write returns the old data. Each port takes at most one request every two cycles. A request that arrives while that port's burst is still in progress is dropped.

Top module: `ddrBurstSram`

## Requirements
- R1: While reset is held and after it is released, `dOutValid` is 0 and both output data lanes are 0 until a read delivers data.
- R2: A write stores four beats. Beat 0 is taken from `dInRise` and beat 1 from `dInFall` in the first data cycle, and beats 2 and 3 come the same way in the second. A later read returns beat 0 on `dOutRise` and beat 1 on `dOutFall` in its first valid cycle, then beats 2 and 3 in the second.
- R3: A read request sampled on rising edge t gives its first beat pair on the outputs after edge t+2 and its second pair after edge t+3. `dOutValid` is high for exactly those two cycles.
- R4: Each address value selects its own group of four beats. Writing one address leaves the words at other addresses unchanged.
- R5: Enable bit j of `bweRise` or `bweFall` covers bits 9j+8 down to 9j of that beat: bit 0 covers 8:0, bit 1 covers 17:9, bit 2 covers 26:18 and bit 3 covers 35:27. A 1 writes the lane. A 0 leaves that lane of that beat unchanged. Every beat follows only its own enables.
- R6: Write data is sampled on the two rising edges that follow the edge that accepts the write request.
- R7: A read sampled on the same edge as a write to the same address, or one cycle after it, returns the new data. A read sampled one cycle before that write returns the old data.
- R8: A read and a write to different addresses may be accepted on the same edge. The read returns the old contents of its own address, and the write still completes.
- R9: A request on a port in the cycle right after that port accepted one is ignored. An ignored write changes no stored data, and an ignored read produces no valid cycles.
- R10: Read requests spaced exactly two cycles apart give an unbroken run of valid output cycles, with each burst in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read request strobe |
| rdAddr | input | ADDR_W | Read burst address |
| wrReq | input | 1 | Write request strobe |
| wrAddr | input | ADDR_W | Write burst address |
| dInRise | input | DATA_W | Write beat for the rising half of the cycle |
| bweRise | input | DATA_W/LANE_W | Byte-lane enables for the rising-half beat |
| dInFall | input | DATA_W | Write beat for the falling half of the cycle |
| bweFall | input | DATA_W/LANE_W | Byte-lane enables for the falling-half beat |
| dOutRise | output | DATA_W | Read beat for the rising half of the cycle |
| dOutFall | output | DATA_W | Read beat for the falling half of the cycle |
| dOutValid | output | 1 | High while a read beat pair is on the outputs |

## Verification
The assertions assume that the request pins hold known values from the first clock edge after reset is released. They also assume that write data and enables are presented in the two cycles after an accepted write, since the strobe ordering they check follows from that schedule. The stimulus changes every input only on falling edges and drives all pins to defined values from time zero. It places write beats exactly in the two cycles that follow each accepted write request. It breaks the two-cycle spacing only on purpose, to show that the extra request is dropped.

// File: rtl/ddrBurstSramPkg.sv
`timescale 1ns/1ps
package ddrBurstSramPkg;

  localparam int BEATS = 4;

  // Strobes passed from control to datapath, one per cycle
  typedef struct packed {
    logic capLo;   // latch beats 0/1 of a write
    logic commit;  // write the merged wide word into the array
    logic fetch;   // read the wide word, drive beats 0/1
    logic sendHi;  // drive beats 2/3 of the fetched word
  } sramStrobeT;

endpackage

// File: rtl/ddrBurstSramCtrl.sv
`timescale 1ns/1ps
module ddrBurstSramCtrl
  import ddrBurstSramPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  output sramStrobeT        str,
  output logic [ADDR_W-1:0] rdAddrQ,
  output logic [ADDR_W-1:0] wrAddrQ
);

  logic wrS1, wrS2;
  logic rdS1, rdS2, rdS3;
  logic wrAccept, rdAccept;

  // A port is busy only in the cycle after it accepts
  assign wrAccept = wrReq && !wrS1;
  assign rdAccept = rdReq && !rdS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrS1    <= 1'b0;
      wrS2    <= 1'b0;
      rdS1    <= 1'b0;
      rdS2    <= 1'b0;
      rdS3    <= 1'b0;
      wrAddrQ <= '0;
      rdAddrQ <= '0;
    end else begin
      wrS1 <= wrAccept;
      wrS2 <= wrS1;
      rdS1 <= rdAccept;
      rdS2 <= rdS1;
      rdS3 <= rdS2;
      if (wrAccept) wrAddrQ <= wrAddr;
      if (rdAccept) rdAddrQ <= rdAddr;
    end
  end

  always_comb begin
    str.capLo  = wrS1;
    str.commit = wrS2;
    str.fetch  = rdS2;
    str.sendHi = rdS3;
  end

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdS1) |=> ##1 str.fetch);

  // R9
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.capLo |=> !str.capLo);

endmodule

// File: rtl/ddrBurstSramDatapath.sv
`timescale 1ns/1ps
module ddrBurstSramDatapath
  import ddrBurstSramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sramStrobeT               str,
  input  logic [ADDR_W-1:0]        rdAddrQ,
  input  logic [ADDR_W-1:0]        wrAddrQ,
  input  logic [DATA_W-1:0]        dInRise,
  input  logic [DATA_W/LANE_W-1:0] bweRise,
  input  logic [DATA_W-1:0]        dInFall,
  input  logic [DATA_W/LANE_W-1:0] bweFall,
  output logic [DATA_W-1:0]        dOutRise,
  output logic [DATA_W-1:0]        dOutFall,
  output logic                     dOutValid
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int WORD_W = BEATS * DATA_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0]     mem [DEPTH];
  logic [2*DATA_W-1:0]   loBeats;
  logic [2*LANES-1:0]    loBe;
  logic [WORD_W-1:0]     newWord;
  logic [BEATS*LANES-1:0] newBe;
  logic [WORD_W-1:0]     oldWord;
  logic [WORD_W-1:0]     mergedWord;
  logic [WORD_W-1:0]     rdWord;
  logic [2*DATA_W-1:0]   hiHold;

  // Beat k sits at bits [k*DATA_W +: DATA_W] of the wide word
  assign newWord = {dInFall, dInRise, loBeats};
  assign newBe   = {bweFall, bweRise, loBe};
  assign oldWord = mem[wrAddrQ];

  for (genvar gBeat = 0; gBeat < BEATS; gBeat++) begin : gBeatMerge
    for (genvar gLane = 0; gLane < LANES; gLane++) begin : gLaneMerge
      localparam int OFS = gBeat * DATA_W + gLane * LANE_W;
      assign mergedWord[OFS +: LANE_W] = newBe[gBeat*LANES + gLane]
                                         ? newWord[OFS +: LANE_W]
                                         : oldWord[OFS +: LANE_W];
    end
  end

  // Forward a commit landing on the same edge as the fetch
  assign rdWord = (str.commit && (wrAddrQ == rdAddrQ)) ? mergedWord : mem[rdAddrQ];

  always_ff @(posedge clk) begin
    if (str.commit) mem[wrAddrQ] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loBeats <= '0;
      loBe    <= '0;
    end else if (str.capLo) begin
      loBeats <= {dInFall, dInRise};
      loBe    <= {bweFall, bweRise};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOutRise  <= '0;
      dOutFall  <= '0;
      dOutValid <= 1'b0;
      hiHold    <= '0;
    end else if (str.fetch) begin
      dOutRise  <= rdWord[0 +: DATA_W];
      dOutFall  <= rdWord[DATA_W +: DATA_W];
      hiHold    <= rdWord[2*DATA_W +: 2*DATA_W];
      dOutValid <= 1'b1;
    end else if (str.sendHi) begin
      dOutRise  <= hiHold[0 +: DATA_W];
      dOutFall  <= hiHold[DATA_W +: DATA_W];
      dOutValid <= 1'b1;
    end else begin
      dOutRise  <= '0;
      dOutFall  <= '0;
      dOutValid <= 1'b0;
    end
  end

  // R6
  cap_then_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.capLo |=> str.commit);

  // R3
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.fetch |=> (dOutValid && str.sendHi));

  // R10
  no_beat_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.fetch && str.sendHi));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.fetch && !str.sendHi) |=> !dOutValid);

endmodule

// File: rtl/ddrBurstSram.sv
`timescale 1ns/1ps
module ddrBurstSram
  import ddrBurstSramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdReq,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic                     wrReq,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        dInRise,
  input  logic [DATA_W/LANE_W-1:0] bweRise,
  input  logic [DATA_W-1:0]        dInFall,
  input  logic [DATA_W/LANE_W-1:0] bweFall,
  output logic [DATA_W-1:0]        dOutRise,
  output logic [DATA_W-1:0]        dOutFall,
  output logic                     dOutValid
);

  sramStrobeT        str;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [ADDR_W-1:0] wrAddrQ;

  ddrBurstSramCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdReq   (rdReq),
    .rdAddr  (rdAddr),
    .wrReq   (wrReq),
    .wrAddr  (wrAddr),
    .str     (str),
    .rdAddrQ (rdAddrQ),
    .wrAddrQ (wrAddrQ)
  );

  ddrBurstSramDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .rdAddrQ   (rdAddrQ),
    .wrAddrQ   (wrAddrQ),
    .dInRise   (dInRise),
    .bweRise   (bweRise),
    .dInFall   (dInFall),
    .bweFall   (bweFall),
    .dOutRise  (dOutRise),
    .dOutFall  (dOutFall),
    .dOutValid (dOutValid)
  );

endmodule

// File: tb/test_ddrBurstSram.sv
`timescale 1ns/1ps
module test_ddrBurstSram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0, wrReq = 1'b0;
  logic [3:0]  rdAddr = '0, wrAddr = '0;
  logic [35:0] dInRise = '0, dInFall = '0;
  logic [3:0]  bweRise = '0, bweFall = '0;
  logic [35:0] dOutRise, dOutFall;
  logic        dOutValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [35:0] refMem [16][4];

  always #4 clk = ~clk;

  ddrBurstSram i_ddrBurstSram (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .wrReq(wrReq), .wrAddr(wrAddr), .dInRise(dInRise), .bweRise(bweRise),
    .dInFall(dInFall), .bweFall(bweFall), .dOutRise(dOutRise),
    .dOutFall(dOutFall), .dOutValid(dOutValid)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected merge from R5: lane j of a beat is bits 9j+8:9j, written when its enable is 1
  task automatic applyRef(input logic [3:0] a, input logic [3:0][35:0] w, input logic [3:0][3:0] be);
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++)
        if (be[k][j]) refMem[a][k][j*9 +: 9] = w[k][j*9 +: 9];
  endtask

  task automatic setLo(input logic [3:0][35:0] w, input logic [3:0][3:0] be);
    dInRise = w[0]; dInFall = w[1]; bweRise = be[0]; bweFall = be[1];
  endtask

  task automatic setHi(input logic [3:0][35:0] w, input logic [3:0][3:0] be);
    dInRise = w[2]; dInFall = w[3]; bweRise = be[2]; bweFall = be[3];
  endtask

  task automatic clrIn;
    dInRise = '0; dInFall = '0; bweRise = '0; bweFall = '0;
  endtask

  task automatic wrBurst(input logic [3:0] a, input logic [3:0][35:0] w, input logic [3:0][3:0] be);
    wrReq = 1'b1; wrAddr = a;
    tick;
    wrReq = 1'b0; setLo(w, be);
    tick;
    setHi(w, be);
    tick;
    clrIn;
    applyRef(a, w, be);
  endtask

  task automatic chkPair(input string tag, input logic [35:0] eR, input logic [35:0] eF);
    chk({tag, " valid"}, {35'd0, dOutValid}, 36'd1);
    chk({tag, " rise"}, dOutRise, eR);
    chk({tag, " fall"}, dOutFall, eF);
  endtask

  // Full read of one burst, checked against the model (R2, R3)
  task automatic rdCheck(input string tag, input logic [3:0] a);
    logic [35:0] e [4];
    for (int k = 0; k < 4; k++) e[k] = refMem[a][k];
    rdReq = 1'b1; rdAddr = a;
    tick;
    rdReq = 1'b0;
    tick;
    chk({tag, " R3 no early valid"}, {35'd0, dOutValid}, 36'd0);
    tick;
    chkPair({tag, " R2 beats 0/1"}, e[0], e[1]);
    tick;
    chkPair({tag, " R2 beats 2/3"}, e[2], e[3]);
    tick;
    chk({tag, " R3 valid ends"}, {35'd0, dOutValid}, 36'd0);
  endtask

  function automatic logic [3:0][35:0] pat(input logic [7:0] seed);
    logic [3:0][35:0] w;
    for (int k = 0; k < 4; k++) w[k] = {seed, 4'(k), 24'h5A0000 ^ {seed, seed, seed}} + 36'(k * 7);
    return w;
  endfunction

  localparam logic [3:0][3:0] ALL = {4'hF, 4'hF, 4'hF, 4'hF};

  task automatic testReset;
    chk("R1 valid after reset", {35'd0, dOutValid}, 36'd0);
    chk("R1 rise after reset", dOutRise, 36'd0);
    chk("R1 fall after reset", dOutFall, 36'd0);
  endtask

  task automatic testBasic;
    wrBurst(4'd3, pat(8'h11), ALL);
    rdCheck("R6 basic", 4'd3);
  endtask

  task automatic testAddr;
    wrBurst(4'd0, pat(8'h22), ALL);
    wrBurst(4'd15, pat(8'h33), ALL);
    rdCheck("R4 addr0", 4'd0);
    rdCheck("R4 addr15", 4'd15);
    rdCheck("R4 addr3 kept", 4'd3);
  endtask

  task automatic testMask;
    logic [3:0][3:0] be;
    wrBurst(4'd5, pat(8'h44), ALL);
    be[0] = 4'b0001; be[1] = 4'b1010; be[2] = 4'b0000; be[3] = 4'b1100;
    wrBurst(4'd5, pat(8'hC7), be);
    rdCheck("R5 lanes", 4'd5);
  endtask

  task automatic testCoherent;
    logic [3:0][35:0] w;
    // Same edge
    wrBurst(4'd7, pat(8'h55), ALL);
    w = pat(8'h66);
    wrReq = 1'b1; wrAddr = 4'd7; rdReq = 1'b1; rdAddr = 4'd7;
    tick; wrReq = 1'b0; rdReq = 1'b0; setLo(w, ALL);
    tick; setHi(w, ALL);
    tick; clrIn; applyRef(4'd7, w, ALL);
    chkPair("R7 same edge lo", refMem[7][0], refMem[7][1]);
    tick; chkPair("R7 same edge hi", refMem[7][2], refMem[7][3]);
    tick;
    // Read one cycle after the write
    w = pat(8'h77);
    wrReq = 1'b1; wrAddr = 4'd7;
    tick; wrReq = 1'b0; setLo(w, ALL); rdReq = 1'b1; rdAddr = 4'd7;
    tick; rdReq = 1'b0; setHi(w, ALL);
    tick; clrIn; applyRef(4'd7, w, ALL);
    tick; chkPair("R7 after lo", refMem[7][0], refMem[7][1]);
    tick; chkPair("R7 after hi", refMem[7][2], refMem[7][3]);
    tick;
    // Read one cycle before the write returns old data
    begin
      logic [35:0] o [4];
      for (int k = 0; k < 4; k++) o[k] = refMem[7][k];
      w = pat(8'h88);
      rdReq = 1'b1; rdAddr = 4'd7;
      tick; rdReq = 1'b0; wrReq = 1'b1; wrAddr = 4'd7;
      tick; wrReq = 1'b0; setLo(w, ALL);
      tick; setHi(w, ALL);
      chkPair("R7 before lo", o[0], o[1]);
      tick; clrIn; applyRef(4'd7, w, ALL);
      chkPair("R7 before hi", o[2], o[3]);
      tick;
    end
    rdCheck("R7 final", 4'd7);
  endtask

  task automatic testSimul;
    logic [3:0][35:0] w;
    w = pat(8'h99);
    wrReq = 1'b1; wrAddr = 4'd9; rdReq = 1'b1; rdAddr = 4'd3;
    tick; wrReq = 1'b0; rdReq = 1'b0; setLo(w, ALL);
    tick; setHi(w, ALL);
    tick; clrIn; applyRef(4'd9, w, ALL);
    chkPair("R8 read lo", refMem[3][0], refMem[3][1]);
    tick; chkPair("R8 read hi", refMem[3][2], refMem[3][3]);
    tick;
    rdCheck("R8 write landed", 4'd9);
  endtask

  task automatic testIgnore;
    logic [3:0][35:0] w;
    wrBurst(4'd11, pat(8'hAA), ALL);
    w = pat(8'hBB);
    wrReq = 1'b1; wrAddr = 4'd10;
    tick; wrAddr = 4'd11; setLo(w, ALL);   // wrReq held: second request dropped
    tick; wrReq = 1'b0; setHi(w, ALL);
    tick; clrIn; applyRef(4'd10, w, ALL);
    rdCheck("R9 dropped write", 4'd11);
    rdCheck("R9 first write", 4'd10);
    // Read held for two cycles: only one burst
    rdReq = 1'b1; rdAddr = 4'd10;
    tick; rdAddr = 4'd11;
    tick; rdReq = 1'b0;
    tick; chkPair("R9 read lo", refMem[10][0], refMem[10][1]);
    tick; chkPair("R9 read hi", refMem[10][2], refMem[10][3]);
    tick; chk("R9 no extra valid", {35'd0, dOutValid}, 36'd0);
    tick; chk("R9 still idle", {35'd0, dOutValid}, 36'd0);
  endtask

  task automatic testBackToBack;
    rdReq = 1'b1; rdAddr = 4'd3;
    tick; rdReq = 1'b0;
    tick; rdReq = 1'b1; rdAddr = 4'd5;
    tick; rdReq = 1'b0;
    chkPair("R10 first lo", refMem[3][0], refMem[3][1]);
    tick; chkPair("R10 first hi", refMem[3][2], refMem[3][3]);
    tick; chkPair("R10 second lo", refMem[5][0], refMem[5][1]);
    tick; chkPair("R10 second hi", refMem[5][2], refMem[5][3]);
    tick; chk("R10 valid ends", {35'd0, dOutValid}, 36'd0);
  endtask

  initial begin
    for (int a = 0; a < 16; a++)
      for (int k = 0; k < 4; k++) refMem[a][k] = '0;
    repeat (3) tick;
    testReset;
    rstN = 1'b1;
    tick;
    testReset;
    testBasic;
    testAddr;
    testMask;
    testCoherent;
    testSimul;
    testIgnore;
    testBackToBack;
    tick;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule